// File: doc/BRIEF.md
# Polled Interrupt Acceptance Controller

This block decides when a CPU core takes an interrupt from one of five sources: external request 0, external request 1, timer 0, timer 1 and the serial port. A machine cycle is `PHASES` clocks long. On the last clock of every machine cycle the block takes a snapshot of the request vector. On the last clock of the next machine cycle it judges that snapshot against the enable and priority masks, the in-service state and the instruction status that the core supplies. An accepted request gives a one-clock `irq_take` pulse with a 3-bit vector index and the priority level of the accepted source.

There are two priority levels, high and low. The in-service state holds one bit per level. Acceptance sets the bit for the accepted level, so a high-priority request can nest above a running low-priority handler. A return-from-interrupt clears the highest bit that is set. Each source keeps its request flag by its own rule. An external source latches falling edges in edge mode and follows its pin in level mode. Timer flags clear themselves when accepted. The serial-port flag clears only when software clears it.

Top module: `irq_accept_ctrl`

## Requirements
- R1: During reset and after it, `irq_take` is 0 and `in_svc` is 0. All request flags and the snapshot are clear.
- R2: The snapshot is taken on the clock edge that ends each machine cycle (phase `PHASES-1`, counted from 0 after reset). The acceptance decision is made on the edge that ends the following machine cycle. `irq_take` is high for exactly the one clock after that edge.
- R3: A high-priority candidate wins over a low-priority one. Within a level, the fixed order is external 0, timer 0, external 1, timer 1, serial port. `irq_vec` gives that position as 0 to 4, and `irq_lvl` is 1 for high. Both are 0 when `irq_take` is 0. Bit i of `src_en`, `src_hi` and `sw_clr` belongs to source i in this order.
- R4: `in_svc[1]` marks a high handler and `in_svc[0]` a low handler. A high request is accepted only while `in_svc[1]` is 0. A low request is accepted only while `in_svc` is 0. Acceptance sets the bit for its level.
- R5: No request is accepted at a decision edge where `last_cycle` is 0, `reti_exec` is 1 or `ctl_write` is 1. A latched flag stays pending and is accepted at a later decision edge that is not blocked.
- R6: In edge mode (`ext_edge_mode` bit 1), a falling edge on the synchronized pin sets the flag of an external source. Acceptance of that source clears the flag, and so does its `sw_clr` bit.
- R7: In level mode (`ext_edge_mode` bit 0), the request of an external source is its synchronized pin being low, and nothing is latched. A low level that is gone before it is accepted leaves no request behind.
- R8: A one-clock `tmr_ovf` pulse sets the flag of that timer. The flag clears when the timer is accepted or when its `sw_clr` bit is set. If a set and a clear happen on the same edge, the set wins.
- R9: The serial-port flag is set by `uart_req` and cleared only by `sw_clr[4]`. Acceptance leaves it pending, so it is accepted again after the return.
- R10: A decision edge with `reti_exec` high clears `in_svc[1]` if it is set, and otherwise clears `in_svc[0]`.
- R11: A pending source whose `src_en` bit is 0 is not accepted. Its flag stays set and is accepted once it is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one phase per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_pin | input | 2 | External request pins [0]=ext 0, [1]=ext 1, active low |
| ext_edge_mode | input | 2 | 1 = edge mode, 0 = level mode, per external source |
| tmr_ovf | input | 2 | Timer overflow pulses [0]=timer 0, [1]=timer 1 |
| uart_req | input | 1 | Serial-port request pulse |
| src_en | input | 5 | Enable per source, in vector order |
| src_hi | input | 5 | 1 = high priority, per source |
| sw_clr | input | 5 | Software flag-clear strobes, per source |
| last_cycle | input | 1 | Current cycle is the final one of its instruction |
| reti_exec | input | 1 | Current instruction is a return from interrupt |
| ctl_write | input | 1 | Current instruction writes an enable or priority register |
| irq_take | output | 1 | Acceptance pulse |
| irq_vec | output | 3 | Index of the accepted source |
| irq_lvl | output | 1 | Level of the accepted source, 1 = high |
| in_svc | output | 2 | In-service bits [1]=high, [0]=low |

## Verification
The hardest state to reach is a high-priority handler nested above a low one while a third request waits behind it. The bench takes a low timer request first, then raises the serial port at high priority so that `in_svc` becomes 3. It then holds a high-priority timer pulse through several decision edges and checks that it stays pending until one return releases only the upper bit. A second hard case is a level-mode request that goes away unseen. The pin is held low while the source is disabled, then released, and the source is enabled only after a fresh snapshot has replaced the old one.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NSRC = 5;
  localparam int VW   = 3;
  // sources whose flags clear by hardware on acceptance (ext 0, tmr 0, ext 1, tmr 1)
  localparam logic [NSRC-1:0] HW_CLR_MASK = 5'b01111;

  // lowest set index, 0 when none
  function automatic logic [VW-1:0] first_set(input logic [NSRC-1:0] v);
    logic [VW-1:0] r;
    r = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (v[i]) r = VW'(i);
    end
    return r;
  endfunction

  // release the most significant in-service bit
  function automatic logic [1:0] drop_top(input logic [1:0] s);
    return s[1] ? {1'b0, s[0]} : 2'b00;
  endfunction
endpackage

// File: rtl/irq_src_flags.sv
module irq_src_flags
  import irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      ext_pin,
  input  logic [1:0]      ext_edge_mode,
  input  logic [1:0]      tmr_ovf,
  input  logic            uart_req,
  input  logic [NSRC-1:0] sw_clr,
  input  logic [NSRC-1:0] hw_clr,
  output logic [NSRC-1:0] req,
  output logic [1:0]      ext_fall
);
  for (genvar e = 0; e < 2; e++) begin : g_ext
    logic s1, s2, s3, lat;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        s1 <= 1'b1;
        s2 <= 1'b1;
        s3 <= 1'b1;
      end else begin
        s1 <= ext_pin[e];
        s2 <= s1;
        s3 <= s2;
      end
    end
    assign ext_fall[e] = s3 & ~s2;
    always_ff @(posedge clk) begin
      if (!rst_n)                                  lat <= 1'b0;
      else if (!ext_edge_mode[e])                  lat <= 1'b0;
      else if (ext_fall[e])                        lat <= 1'b1;
      else if (hw_clr[2*e] || sw_clr[2*e])         lat <= 1'b0;
    end
    assign req[2*e] = ext_edge_mode[e] ? lat : ~s2;
  end

  for (genvar t = 0; t < 2; t++) begin : g_tmr
    logic lat;
    always_ff @(posedge clk) begin
      if (!rst_n)                                  lat <= 1'b0;
      else if (tmr_ovf[t])                         lat <= 1'b1;
      else if (hw_clr[2*t+1] || sw_clr[2*t+1])     lat <= 1'b0;
    end
    assign req[2*t+1] = lat;
  end

  logic uart_lat;
  always_ff @(posedge clk) begin
    if (!rst_n)                uart_lat <= 1'b0;
    else if (uart_req)         uart_lat <= 1'b1;
    else if (sw_clr[NSRC-1])   uart_lat <= 1'b0;
  end
  assign req[NSRC-1] = uart_lat;
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
(
  input  logic [NSRC-1:0] polled,
  input  logic [NSRC-1:0] src_en,
  input  logic [NSRC-1:0] src_hi,
  input  logic [1:0]      in_svc,
  input  logic            gate_ok,
  output logic            take,
  output logic [VW-1:0]   vec,
  output logic            lvl
);
  logic [NSRC-1:0] hi_c, lo_c;
  logic hi_ok, lo_ok;

  assign hi_c  = polled & src_en & src_hi;
  assign lo_c  = polled & src_en & ~src_hi;
  assign hi_ok = (|hi_c) && !in_svc[1];
  assign lo_ok = (|lo_c) && (in_svc == 2'b00);
  assign take  = gate_ok && (hi_ok || lo_ok);
  assign lvl   = hi_ok;
  assign vec   = hi_ok ? first_set(hi_c) : first_set(lo_c);
endmodule

// File: rtl/irq_svc_track.sv
module irq_svc_track
  import irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set_en,
  input  logic       set_lvl,
  input  logic       release_en,
  output logic [1:0] in_svc
);
  always_ff @(posedge clk) begin
    if (!rst_n)          in_svc <= 2'b00;
    else if (set_en)     in_svc[set_lvl] <= 1'b1;
    else if (release_en) in_svc <= drop_top(in_svc);
  end
endmodule

// File: rtl/irq_accept_ctrl.sv
module irq_accept_ctrl
  import irq_pkg::*;
#(
  parameter int PHASES = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  ext_pin,
  input  logic [1:0]  ext_edge_mode,
  input  logic [1:0]  tmr_ovf,
  input  logic        uart_req,
  input  logic [4:0]  src_en,
  input  logic [4:0]  src_hi,
  input  logic [4:0]  sw_clr,
  input  logic        last_cycle,
  input  logic        reti_exec,
  input  logic        ctl_write,
  output logic        irq_take,
  output logic [2:0]  irq_vec,
  output logic        irq_lvl,
  output logic [1:0]  in_svc
);
  localparam int PW = (PHASES > 1) ? $clog2(PHASES) : 1;
  localparam logic [PW-1:0] LAST = PW'(PHASES - 1);

  logic [PW-1:0]   phase;
  logic            poll_now, gate_ok, take_now, lvl_now, release_now;
  logic [VW-1:0]   vec_now;
  logic [NSRC-1:0] req, snap, hw_clr;
  logic [1:0]      ext_fall;

  always_ff @(posedge clk) begin
    if (!rst_n)        phase <= '0;
    else if (poll_now) phase <= '0;
    else               phase <= phase + 1'b1;
  end

  assign poll_now    = (phase == LAST);
  assign gate_ok     = poll_now && last_cycle && !reti_exec && !ctl_write;
  assign release_now = poll_now && reti_exec;
  assign hw_clr      = take_now ? ((NSRC'(1) << vec_now) & HW_CLR_MASK) : '0;

  irq_src_flags u_flags (
    .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .ext_edge_mode(ext_edge_mode),
    .tmr_ovf(tmr_ovf), .uart_req(uart_req), .sw_clr(sw_clr), .hw_clr(hw_clr),
    .req(req), .ext_fall(ext_fall)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)        snap <= '0;
    else if (poll_now) snap <= req & ~hw_clr;
  end

  irq_arbiter u_arb (
    .polled(snap), .src_en(src_en), .src_hi(src_hi), .in_svc(in_svc),
    .gate_ok(gate_ok), .take(take_now), .vec(vec_now), .lvl(lvl_now)
  );

  irq_svc_track u_svc (
    .clk(clk), .rst_n(rst_n), .set_en(take_now), .set_lvl(lvl_now),
    .release_en(release_now), .in_svc(in_svc)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_take <= 1'b0;
      irq_vec  <= '0;
      irq_lvl  <= 1'b0;
    end else begin
      irq_take <= take_now;
      irq_vec  <= take_now ? vec_now : '0;
      irq_lvl  <= take_now && lvl_now;
    end
  end
endmodule

// File: rtl/irq_accept_chk.sv
module irq_accept_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       poll_now,
  input logic       last_cycle,
  input logic       reti_exec,
  input logic       ctl_write,
  input logic       irq_take,
  input logic [2:0] irq_vec,
  input logic       irq_lvl,
  input logic [1:0] in_svc
);
  assert_take_after_poll_R2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> $past(poll_now));
  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |=> !irq_take);
  assert_vec_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> (irq_vec < 3'd5));
  assert_level_marked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> in_svc[irq_lvl]);
  assert_low_needs_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_take && !irq_lvl) |-> ($past(in_svc) == 2'b00));
  assert_high_no_nest_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_take && irq_lvl) |-> !$past(in_svc[1]));
  assert_blocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_now && (!last_cycle || reti_exec || ctl_write)) |=> !irq_take);
  assert_release_top_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_now && reti_exec && in_svc[1]) |=> (in_svc == {1'b0, $past(in_svc[0])}));
endmodule

bind irq_accept_ctrl irq_accept_chk u_chk (
  .clk(clk), .rst_n(rst_n), .poll_now(poll_now), .last_cycle(last_cycle),
  .reti_exec(reti_exec), .ctl_write(ctl_write), .irq_take(irq_take),
  .irq_vec(irq_vec), .irq_lvl(irq_lvl), .in_svc(in_svc)
);

// File: tb/irq_accept_ctrl_test.sv
module irq_accept_ctrl_test;
  localparam int P = 4;

  logic clk = 0;
  logic rst_n = 0;
  logic [1:0] ext_pin = 2'b11, ext_edge_mode = 2'b11, tmr_ovf = 2'b00;
  logic uart_req = 0;
  logic [4:0] src_en = 5'b11111, src_hi = 5'b00000, sw_clr = 5'b00000;
  logic last_cycle = 1, reti_exec = 0, ctl_write = 0;
  logic irq_take, irq_lvl;
  logic [2:0] irq_vec;
  logic [1:0] in_svc;

  int total = 0, bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  irq_accept_ctrl #(.PHASES(P)) uut (
    .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .ext_edge_mode(ext_edge_mode),
    .tmr_ovf(tmr_ovf), .uart_req(uart_req), .src_en(src_en), .src_hi(src_hi),
    .sw_clr(sw_clr), .last_cycle(last_cycle), .reti_exec(reti_exec),
    .ctl_write(ctl_write), .irq_take(irq_take), .irq_vec(irq_vec),
    .irq_lvl(irq_lvl), .in_svc(in_svc)
  );

  // behavioural reference, updated on every rising edge
  int  m_phase;
  int  pin_d[3][2];
  bit  m_flag[5], m_snap[5], m_isv[2];
  bit  e_take, e_lvl;
  int  e_vec;

  always @(posedge clk) begin
    bit req[5];
    bit fall[2];
    int acc;
    bit alvl, poll;
    if (!rst_n) begin
      m_phase = 0;
      for (int k = 0; k < 3; k++) for (int e = 0; e < 2; e++) pin_d[k][e] = 1;
      for (int i = 0; i < 5; i++) begin m_flag[i] = 0; m_snap[i] = 0; end
      m_isv[0] = 0; m_isv[1] = 0;
      e_take = 0; e_vec = 0; e_lvl = 0;
    end else begin
      poll = (m_phase == P - 1);
      for (int e = 0; e < 2; e++) begin
        fall[e] = (pin_d[2][e] == 1) && (pin_d[1][e] == 0);
        req[2*e] = ext_edge_mode[e] ? m_flag[2*e] : (pin_d[1][e] == 0);
      end
      req[1] = m_flag[1]; req[3] = m_flag[3]; req[4] = m_flag[4];
      acc = -1; alvl = 0;
      if (poll && last_cycle && !reti_exec && !ctl_write) begin
        if (!m_isv[1])
          for (int i = 0; i < 5; i++)
            if (acc < 0 && m_snap[i] && src_en[i] && src_hi[i]) begin acc = i; alvl = 1; end
        if (acc < 0 && !m_isv[0] && !m_isv[1])
          for (int i = 0; i < 5; i++)
            if (acc < 0 && m_snap[i] && src_en[i] && !src_hi[i]) acc = i;
      end
      if (poll) for (int i = 0; i < 5; i++) m_snap[i] = req[i] && !(i == acc && i != 4);
      for (int e = 0; e < 2; e++) begin
        if (!ext_edge_mode[e]) m_flag[2*e] = 0;
        else if (fall[e]) m_flag[2*e] = 1;
        else if (acc == 2*e || sw_clr[2*e]) m_flag[2*e] = 0;
        if (tmr_ovf[e]) m_flag[2*e+1] = 1;
        else if (acc == 2*e+1 || sw_clr[2*e+1]) m_flag[2*e+1] = 0;
      end
      if (uart_req) m_flag[4] = 1;
      else if (sw_clr[4]) m_flag[4] = 0;
      if (acc >= 0) m_isv[alvl] = 1;
      else if (poll && reti_exec) begin
        if (m_isv[1]) m_isv[1] = 0; else m_isv[0] = 0;
      end
      e_take = (acc >= 0); e_vec = (acc >= 0) ? acc : 0; e_lvl = alvl;
      for (int e = 0; e < 2; e++) begin
        pin_d[2][e] = pin_d[1][e]; pin_d[1][e] = pin_d[0][e]; pin_d[0][e] = ext_pin[e];
      end
      m_phase = (m_phase + 1) % P;
    end
  end

  // per-clock comparison
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      total++;
      if (irq_take !== e_take) begin
        bad++; $display("FAIL R2 take actual=%0d expected=%0d", irq_take, e_take);
      end else if (irq_vec !== 3'(e_vec) || irq_lvl !== e_lvl) begin
        bad++; $display("FAIL R3 vec/lvl actual=%0d/%0d expected=%0d/%0d", irq_vec, irq_lvl, e_vec, e_lvl);
      end else if (in_svc !== {m_isv[1], m_isv[0]}) begin
        bad++; $display("FAIL R4 in_svc actual=%0d expected=%0d", in_svc, {m_isv[1], m_isv[0]});
      end
    end
  end

  task automatic wait_take(input int ev, input bit el, input string tag);
    bit seen = 0;
    for (int k = 0; k < 16 && !seen; k++) begin
      @(negedge clk);
      if (irq_take) seen = 1;
    end
    total++;
    if (!seen || irq_vec != 3'(ev) || irq_lvl != el) begin
      bad++;
      $display("FAIL %s actual take=%0d vec=%0d lvl=%0d expected take=1 vec=%0d lvl=%0d",
               tag, seen, irq_vec, irq_lvl, ev, el);
    end
  endtask

  task automatic expect_none(input int n, input string tag);
    bit seen = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (irq_take) seen = 1;
    end
    total++;
    if (seen) begin bad++; $display("FAIL %s actual take=1 expected take=0", tag); end
  endtask

  task automatic check_svc(input logic [1:0] ev, input string tag);
    @(negedge clk);
    total++;
    if (in_svc !== ev) begin bad++; $display("FAIL %s in_svc actual=%0d expected=%0d", tag, in_svc, ev); end
  endtask

  task automatic do_reti();
    @(negedge clk); reti_exec = 1;
    repeat (P) @(negedge clk);
    reti_exec = 0;
  endtask

  task automatic pulse_tmr(input int t);
    @(negedge clk); tmr_ovf[t] = 1;
    @(negedge clk); tmr_ovf[t] = 0;
  endtask

  task automatic pulse_uart();
    @(negedge clk); uart_req = 1;
    @(negedge clk); uart_req = 0;
  endtask

  task automatic pulse_clr(input int i);
    @(negedge clk); sw_clr[i] = 1;
    @(negedge clk); sw_clr[i] = 0;
  endtask

  task automatic fall_pin(input int e);
    @(negedge clk); ext_pin[e] = 0;
    repeat (3) @(negedge clk);
    ext_pin[e] = 1;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL R2 watchdog actual=hung expected=finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    total++;
    if (irq_take !== 0 || in_svc !== 2'b00) begin
      bad++; $display("FAIL R1 reset actual take=%0d svc=%0d expected 0/0", irq_take, in_svc);
    end
    rst_n = 1;
    expect_none(12, "R1");

    // R8: timer 0 accepted, R10 return
    pulse_tmr(0);
    wait_take(1, 0, "R8");
    check_svc(2'b01, "R4");
    do_reti();
    check_svc(2'b00, "R10");

    // R3 order at low level, R9 serial flag persistence
    @(negedge clk); tmr_ovf[1] = 1; uart_req = 1; ext_pin[0] = 0;
    @(negedge clk); tmr_ovf[1] = 0; uart_req = 0;
    repeat (2) @(negedge clk); ext_pin[0] = 1;
    wait_take(0, 0, "R3");
    do_reti();
    wait_take(3, 0, "R3");
    do_reti();
    wait_take(4, 0, "R9");
    do_reti();
    wait_take(4, 0, "R9");
    pulse_clr(4);
    repeat (2 * P) @(negedge clk);
    do_reti();
    expect_none(16, "R9");

    // R4 nesting
    src_hi = 5'b11000;
    pulse_tmr(0);
    wait_take(1, 0, "R4");
    pulse_uart();
    wait_take(4, 1, "R4");
    check_svc(2'b11, "R4");
    pulse_clr(4);
    pulse_tmr(1);
    expect_none(16, "R4");
    do_reti();
    wait_take(3, 1, "R10");
    check_svc(2'b11, "R10");
    do_reti();
    check_svc(2'b01, "R10");
    do_reti();
    check_svc(2'b00, "R10");
    src_hi = 5'b00000;

    // R5 blocking conditions
    last_cycle = 0;
    pulse_tmr(0);
    expect_none(16, "R5");
    last_cycle = 1;
    wait_take(1, 0, "R5");
    do_reti();
    ctl_write = 1;
    pulse_tmr(1);
    expect_none(16, "R5");
    ctl_write = 0;
    wait_take(3, 0, "R5");
    do_reti();
    reti_exec = 1;
    pulse_tmr(0);
    expect_none(16, "R5");
    reti_exec = 0;
    wait_take(1, 0, "R5");
    do_reti();

    // R7 level mode
    ext_edge_mode[1] = 0;
    src_en[2] = 0;
    @(negedge clk); ext_pin[1] = 0;
    repeat (12) @(negedge clk);
    ext_pin[1] = 1;
    repeat (3 * P) @(negedge clk);
    src_en[2] = 1;
    expect_none(16, "R7");
    @(negedge clk); ext_pin[1] = 0;
    wait_take(2, 0, "R7");
    ext_pin[1] = 1;
    do_reti();
    expect_none(12, "R7");
    ext_edge_mode[1] = 1;

    // R6 edge mode, software clear and hardware clear
    src_en[0] = 0;
    fall_pin(0);
    repeat (8) @(negedge clk);
    pulse_clr(0);
    repeat (3 * P) @(negedge clk);
    src_en[0] = 1;
    expect_none(16, "R6");
    fall_pin(0);
    wait_take(0, 0, "R6");
    do_reti();
    expect_none(16, "R6");

    // R11 disabled source stays pending
    src_en[3] = 0;
    pulse_tmr(1);
    expect_none(16, "R11");
    src_en[3] = 1;
    wait_take(3, 0, "R11");
    do_reti();
    check_svc(2'b00, "R10");

    repeat (4) @(negedge clk);
    summary();
  end
endmodule